// File: doc/BRIEF.md
# Card Host Idle and Wake-Up Handshake Controller

This block sits beside a storage-card host peripheral and answers the idle request of the system power manager. It decides whether the peripheral may be put to sleep, raises the idle acknowledge when that is safe, and gates the peripheral's interrupt and DMA request lines while it is asleep. Three idle policies are selected by a 2-bit mode input. In force mode every request is acknowledged. In no-idle mode no request is ever acknowledged. In smart mode the block acknowledges only after a quiet window: no transfer running, no interrupt or DMA event pending, and no card interrupt on data line 1.

While the peripheral sleeps in smart mode, a card interrupt on the raw data-line-1 input produces a wake-up request toward the power manager. The request is combinational, so it works with every clock stopped. The block also records that the wake happened. When the power manager drops its idle request, the recorded wake is replayed as the card-interrupt status bit. That bit can then drive the interrupt output through its own signal enable. Software clears it by writing 1.

The controller is a four-state machine. RUN is normal operation. CHECK is the first quiet cycle seen after a smart-mode request. IDLE is the acknowledged sleep. EXIT is the single recovery cycle after the request falls. The transitions are:
- RUN→IDLE on a request in force mode.
- RUN→CHECK on a request in smart mode with the quiet condition met.
- CHECK→IDLE when the request and the quiet condition both still hold.
- CHECK→RUN when the request drops or any event appears.
- IDLE→EXIT when the request falls.
- EXIT→RUN unconditionally.

Top module: `card_idle_hs`

## Requirements
- R1: After reset, idle_ack_o, wake_req_o and cirq_stat_o are 0, and irq_o and dma_o follow evt_irq_i and evt_dma_i.
- R2: While idle_ack_o is 1, irq_o and dma_o are 0 whatever evt_irq_i, evt_dma_i or the status bit hold. Otherwise dma_o equals evt_dma_i.
- R3: In smart mode (idle_mode_i = 2 or 3), the acknowledge rises after the second rising edge that sees the request. The quiet condition must hold at both of those edges. Quiet means xfer_busy_i, evt_irq_i, evt_dma_i and the synchronised card line are all 0. An event at either edge cancels entry, and the request is then re-evaluated from the start.
- R4: In force mode (idle_mode_i = 0), the acknowledge rises after the first rising edge that sees the request, regardless of activity.
- R5: In no-idle mode (idle_mode_i = 1), the acknowledge never rises.
- R6: The acknowledge falls after the first rising edge at which the request is 0.
- R7: wake_req_o is 1 exactly when card_dat1_i, wake_glb_en_i, irq_wake_en_i and cirq_en_i are all 1 and the block is acknowledged-idle having entered from smart mode. It reacts to card_dat1_i without a clock edge.
- R8: card_dat1_i passes through a two-flop synchroniser. Outside the acknowledged idle state, with cirq_en_i = 1, a high line sets cirq_stat_o after the third rising edge.
- R9: A card interrupt seen during smart idle with all three wake enables set is replayed on exit: cirq_stat_o is 1 after the second rising edge following the request's fall, even if the line has returned low.
- R10: Outside idle, irq_o is evt_irq_i OR (cirq_stat_o AND cirq_sig_en_i).
- R11: A 1 on cirq_clr_i clears cirq_stat_o at the next edge, unless a set condition holds at that same edge, in which case the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_req_i | input | 1 | Idle request from the power manager |
| idle_mode_i | input | 2 | 0 force, 1 no-idle, 2/3 smart |
| xfer_busy_i | input | 1 | Block transfer in progress |
| evt_irq_i | input | 1 | Raw interrupt request from the peripheral core |
| evt_dma_i | input | 1 | Raw DMA request from the peripheral core |
| card_dat1_i | input | 1 | Raw card-interrupt level on data line 1 |
| wake_glb_en_i | input | 1 | Global wake-up enable |
| irq_wake_en_i | input | 1 | Card-interrupt wake enable |
| cirq_en_i | input | 1 | Card-interrupt status enable |
| cirq_sig_en_i | input | 1 | Card-interrupt to irq_o signal enable |
| cirq_clr_i | input | 1 | Write-1-to-clear strobe for the status bit |
| idle_ack_o | output | 1 | Idle acknowledge to the power manager |
| wake_req_o | output | 1 | Asynchronous wake-up request |
| irq_o | output | 1 | Gated interrupt request |
| dma_o | output | 1 | Gated DMA request |
| cirq_stat_o | output | 1 | Card-interrupt status bit |

## Verification
The hardest situation to reach is a wake replay that cannot be confused with ordinary status capture. The card line must rise and fall again while the block sits in smart idle, so that when idle ends only the latched wake can set the bit. The bench reaches this by entering smart idle with a quiet peripheral. It then pulses the card line long enough to pass the synchroniser and be latched, waits for the synchroniser to drain, and only then drops the request. It repeats this for all eight combinations of the three wake enables. A cancelled smart entry is reached separately by raising an event in the one cycle spent in CHECK.

// File: rtl/card_idle_pkg.sv
package card_idle_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CHECK = 2'd1,
        ST_IDLE  = 2'd2,
        ST_EXIT  = 2'd3
    } idle_st_e;

    localparam int          MODE_W     = 2;
    localparam logic [1:0]  MODE_FORCE = 2'd0;
    localparam logic [1:0]  MODE_NONE  = 2'd1;

    function automatic logic mode_is_smart(input logic [MODE_W-1:0] m);
        return m[MODE_W-1];
    endfunction

endpackage

// File: rtl/card_line_sync.sv
module card_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[TOP-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[TOP];

endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
    import card_idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_req_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              quiet_i,
    output idle_st_e          state_o,
    output logic              ack_o,
    output logic              ack_smart_o
);
    idle_st_e state_q, state_d;
    logic     smart_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (idle_req_i) begin
                    if (mode_i == MODE_FORCE)
                        state_d = ST_IDLE;
                    else if (mode_is_smart(mode_i) && quiet_i)
                        state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (idle_req_i && quiet_i && mode_is_smart(mode_i))
                    state_d = ST_IDLE;
                else
                    state_d = ST_RUN;
            end
            ST_IDLE: begin
                if (!idle_req_i) state_d = ST_EXIT;
            end
            ST_EXIT: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs: remember whether idle was entered through the smart path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            smart_q <= 1'b0;
        else if (state_q == ST_CHECK && state_d == ST_IDLE)
            smart_q <= 1'b1;
        else if (state_d != ST_IDLE)
            smart_q <= 1'b0;
    end

    assign state_o     = state_q;
    assign ack_o       = (state_q == ST_IDLE);
    assign ack_smart_o = smart_q;

    // R3: a smart entry is only taken after a quiet cycle with request held
    a_r3_smart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && idle_req_i && !quiet_i) |=> state_q == ST_RUN);

    // R4: force mode acknowledges on the first edge
    a_r4_force_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && idle_req_i && mode_i == MODE_FORCE) |=> ack_o);

    // R5: no-idle mode never starts an entry
    a_r5_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode_i == MODE_NONE) |=> !ack_o);

    // R6: acknowledge drops one edge after the request falls
    a_r6_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !idle_req_i) |=> !ack_o);

endmodule

// File: rtl/cirq_status.sv
module cirq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cen_i,
    input  logic wake_en_i,
    input  logic ack_smart_i,
    input  logic in_idle_i,
    input  logic in_exit_i,
    input  logic card_s_i,
    input  logic clr_i,
    output logic stat_o
);
    logic wake_pend_q;
    logic stat_q;
    logic set_now;

    // latch a wake seen while asleep so it survives the line returning low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wake_pend_q <= 1'b0;
        else if (in_exit_i)
            wake_pend_q <= 1'b0;
        else if (in_idle_i && ack_smart_i && wake_en_i && card_s_i)
            wake_pend_q <= 1'b1;
    end

    assign set_now = cen_i && ((card_s_i && !in_idle_i) || (in_exit_i && wake_pend_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stat_q <= 1'b0;
        else if (set_now) stat_q <= 1'b1;
        else if (clr_i)  stat_q <= 1'b0;
    end

    assign stat_o = stat_q;

    // R11: a clear with no competing set empties the bit
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cen_i) |=> !stat_o);

    // R2: status cannot be raised while the acknowledge holds
    a_r2_no_new_stat: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle_i && !stat_o && !in_exit_i) |=> (!stat_o || !in_idle_i || $past(in_exit_i)));

endmodule

// File: rtl/card_idle_hs.sv
module card_idle_hs
    import card_idle_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        idle_req_i,
    input  logic [1:0]  idle_mode_i,
    input  logic        xfer_busy_i,
    input  logic        evt_irq_i,
    input  logic        evt_dma_i,
    input  logic        card_dat1_i,
    input  logic        wake_glb_en_i,
    input  logic        irq_wake_en_i,
    input  logic        cirq_en_i,
    input  logic        cirq_sig_en_i,
    input  logic        cirq_clr_i,
    output logic        idle_ack_o,
    output logic        wake_req_o,
    output logic        irq_o,
    output logic        dma_o,
    output logic        cirq_stat_o
);
    logic     card_s;
    logic     quiet;
    logic     ack;
    logic     ack_smart;
    logic     wake_en;
    logic     stat;
    idle_st_e state;

    card_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (card_dat1_i),
        .q_o   (card_s)
    );

    assign quiet = !xfer_busy_i && !evt_irq_i && !evt_dma_i && !card_s;

    idle_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_req_i  (idle_req_i),
        .mode_i      (idle_mode_i),
        .quiet_i     (quiet),
        .state_o     (state),
        .ack_o       (ack),
        .ack_smart_o (ack_smart)
    );

    assign wake_en = wake_glb_en_i && irq_wake_en_i && cirq_en_i;

    cirq_status i_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .cen_i       (cirq_en_i),
        .wake_en_i   (wake_en),
        .ack_smart_i (ack_smart),
        .in_idle_i   (state == ST_IDLE),
        .in_exit_i   (state == ST_EXIT),
        .card_s_i    (card_s),
        .clr_i       (cirq_clr_i),
        .stat_o      (stat)
    );

    // wake path is pure logic on the raw line so it works with clocks stopped
    assign wake_req_o  = card_dat1_i && wake_en && ack_smart;
    assign idle_ack_o  = ack;
    assign cirq_stat_o = stat;
    assign irq_o       = !ack && (evt_irq_i || (stat && cirq_sig_en_i));
    assign dma_o       = !ack && evt_dma_i;

    // R7: a wake request is only ever raised while acknowledged-idle
    a_r7_wake_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> idle_ack_o);

    // R2: no request line is active during the acknowledge
    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ack_o |-> (!irq_o && !dma_o));

    // R8: a synchronised card level outside idle fills the status bit
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cirq_en_i && card_s && state != ST_IDLE) |=> cirq_stat_o);

endmodule

// File: tb/test_card_idle_hs.sv
module test_card_idle_hs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_req = 1'b0;
    logic [1:0] mode = 2'd2;
    logic       busy = 1'b0, eirq = 1'b0, edma = 1'b0, card = 1'b0;
    logic       glb = 1'b0, iwe = 1'b0, cen = 1'b0, sen = 1'b0, clr = 1'b0;
    logic       ack, wake, irq, dma, stat;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    card_idle_hs i_card_idle_hs (
        .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req), .idle_mode_i(mode),
        .xfer_busy_i(busy), .evt_irq_i(eirq), .evt_dma_i(edma), .card_dat1_i(card),
        .wake_glb_en_i(glb), .irq_wake_en_i(iwe), .cirq_en_i(cen),
        .cirq_sig_en_i(sen), .cirq_clr_i(clr),
        .idle_ack_o(ack), .wake_req_o(wake), .irq_o(irq), .dma_o(dma), .cirq_stat_o(stat)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(2);
        eirq = 1'b1; edma = 1'b1;
        #1;
        chk("R1 ack", ack, 1'b0); chk("R1 wake", wake, 1'b0); chk("R1 stat", stat, 1'b0);
        chk("R1 irq", irq, 1'b1); chk("R1 dma", dma, 1'b1);
        rst_n = 1'b1; eirq = 1'b0; edma = 1'b0;
        tick(1);

        // entry sweep: every mode against every busy/irq/dma mix
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                logic exp_ack;
                mode = m[1:0]; busy = c[2]; eirq = c[1]; edma = c[0];
                idle_req = 1'b1;
                tick(2);
                exp_ack = (m == 0) || (m >= 2 && c == 0);
                chk(m == 0 ? "R4 force" : (m == 1 ? "R5 noidle" : "R3 smart"), ack, exp_ack);
                chk("R2 irq gate", irq, c[1] & ~exp_ack);
                chk("R2 dma gate", dma, c[0] & ~exp_ack);
                idle_req = 1'b0; busy = 1'b0; eirq = 1'b0; edma = 1'b0;
                tick(1);
                chk("R6 drop", ack, 1'b0);
                tick(1);
            end
        end

        // R4: force acknowledges after the first edge
        mode = 2'd0; idle_req = 1'b1; busy = 1'b1;
        tick(1);
        chk("R4 one edge", ack, 1'b1);
        idle_req = 1'b0; busy = 1'b0; tick(2);

        // R3: event during the CHECK cycle cancels, then entry resumes
        mode = 2'd3; idle_req = 1'b1;
        tick(1);
        chk("R3 not yet", ack, 1'b0);
        eirq = 1'b1;
        tick(2);
        chk("R3 cancelled", ack, 1'b0);
        eirq = 1'b0;
        tick(2);
        chk("R3 resumed", ack, 1'b1);
        idle_req = 1'b0; tick(2);

        // R7/R9/R11: wake enables sweep with replay on exit
        sen = 1'b1;
        for (int e = 0; e < 8; e++) begin
            glb = e[2]; iwe = e[1]; cen = e[0];
            mode = 2'd2; idle_req = 1'b1;
            tick(2);
            chk("R3 wake entry", ack, 1'b1);
            card = 1'b1;
            #1;
            chk("R7 wake async", wake, e == 7);
            tick(3);
            chk("R2 stat held", stat, 1'b0);
            card = 1'b0;
            #1;
            chk("R7 wake falls", wake, 1'b0);
            tick(3);
            idle_req = 1'b0;
            tick(2);
            chk("R9 replay", stat, e == 7);
            chk("R10 irq", irq, e == 7);
            clr = 1'b1; tick(1); clr = 1'b0;
            chk("R11 clear", stat, 1'b0);
        end

        // R7: force-mode idle never wakes
        glb = 1'b1; iwe = 1'b1; cen = 1'b1;
        mode = 2'd0; idle_req = 1'b1; tick(1);
        card = 1'b1; #1;
        chk("R7 force nowake", wake, 1'b0);
        card = 1'b0; tick(3);
        idle_req = 1'b0; tick(2);
        chk("R9 force noreplay", stat, 1'b0);

        // R8/R10/R11: normal-mode capture through the synchroniser
        sen = 1'b0; mode = 2'd2; card = 1'b1;
        tick(2);
        chk("R8 two edges", stat, 1'b0);
        tick(1);
        chk("R8 third edge", stat, 1'b1);
        chk("R10 masked", irq, 1'b0);
        sen = 1'b1; #1;
        chk("R10 enabled", irq, 1'b1);
        clr = 1'b1; tick(1); clr = 1'b0;
        chk("R11 set wins", stat, 1'b1);
        card = 1'b0; tick(3);
        clr = 1'b1; tick(1); clr = 1'b0;
        chk("R11 cleared", stat, 1'b0);
        chk("R10 irq low", irq, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule